// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface with Burst Timer

This block sits between a small host processor and the tone generator and tone receiver of a dual-tone signalling transceiver. The host reaches five registers through a 4-bit bus: the digit to send, the last digit received, two control registers that share one address, and a status register. Every access is qualified by an active-low select and a strobe. An access takes effect on the clock edge that follows the end of its strobe.

A hardware burst timer paces transmission. In burst mode, writing a digit produces a tone burst and then a silent pause of the same length. After the pause the transmitter reports that it can take more data. Both phases last 51 ticks of a 1 kHz tick derived from the clock, or 102 ticks in call-progress mode. An active-low interrupt output is driven from the status flags. It can instead show the receiver's delayed steering level when test mode is selected.

The receiver side of the chip feeds the block with a one-cycle pulse when a new code has been latched, plus the code itself and the delayed steering level. Tone synthesis and tone detection live outside this block.

Top module: `tone_xcvr_hostif`

## Requirements
- R1: A selected write with `hostAddr`=0 loads the 4-bit digit register, which drives `txDigit`.
- R2: A selected read with `hostAddr`=0 returns the code that was present on `rxCode` at the last `rxLatched` pulse.
- R3: A selected write with `hostAddr`=1 goes to control register A, with bit 0 = tone enable, bit 1 = call-progress mode, bit 2 = interrupt enable and bit 3 = select B. After a write to A with bit 3 = 1, only the next control write goes to control register B, with bit 0 = burst off (0 selects burst mode), bit 1 = test, bit 2 = single tone (`oneTone`) and bit 3 = high group (`highGroup`). Later control writes go to A again.
- R4: In burst mode, a digit write starts a burst during which `toneGate` equals the tone enable bit, for BURST_TICKS×TICK_DIV cycles. A pause of the same length follows with `toneGate` low. The transmit-empty flag sets on the edge that ends the pause.
- R5: In call-progress mode both the burst and the pause last 2×BURST_TICKS ticks.
- R6: With burst off, `toneGate` follows the tone enable bit directly and the transmit-empty flag is held clear.
- R7: A selected read with `hostAddr`=1 returns status: bit 0 = bit 1 OR bit 2, bit 1 = transmit empty, bit 2 = receive full, bit 3 = NOT `rxSteer`. Bits 0 to 2 clear on the edge ending the read. A flag set on that same edge survives.
- R8: Outside call-progress and test mode, `irqN` is low exactly when interrupts are enabled and status bit 1 or bit 2 is set. In call-progress mode `irqN` stays high.
- R9: In test mode with call-progress off, `irqN` equals NOT `rxSteer`. In call-progress mode the test bit has no effect on `irqN`.
- R10: After reset both control registers are 0 (burst mode, tone off), every flag is clear, `irqN` is high and `toneGate` is low.
- R11: Accesses with `hostSelN` high change no register. `hostRdOe` is high only while a selected read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSelN | input | 1 | Active-low device select |
| hostAddr | input | 1 | 0 = digit registers, 1 = control/status |
| hostRead | input | 1 | 1 = read access, 0 = write access |
| hostStrobe | input | 1 | Bus strobe; the access completes when it falls |
| hostWrData | input | 4 | Write data from host |
| hostRdData | output | 4 | Read data to host (0 when not enabled) |
| hostRdOe | output | 1 | Read data drive enable |
| rxLatched | input | 1 | One-cycle pulse: receiver registered a new code |
| rxCode | input | 4 | Code from the receiver |
| rxSteer | input | 1 | Delayed steering level, high while a valid tone is held |
| txDigit | output | 4 | Digit for the tone generator |
| toneGate | output | 1 | Tone output enable to the generator |
| oneTone | output | 1 | Single-tone select |
| highGroup | output | 1 | High-group select for single tone |
| irqN | output | 1 | Active-low interrupt / test output |

## Verification
Directed bursts in both normal and call-progress mode measure the exact cycle on which the gate drops and on which the ready interrupt appears. This tells a correct phase length apart from a length that is one tick off or not doubled. A long random mix of control writes, receive events, status reads and data reads is checked against a bench model. The model tracks the one-shot B select, the flag clears and the interrupt source. This exposes misrouted control writes and wrong bit positions. Corner cases cover a receive event on the very edge that ends a status read, unselected accesses, test mode with call-progress on and off, and switching burst off.

// File: rtl/tone_xcvr_pkg.sv
package tone_xcvr_pkg;
  localparam int DATA_W = 4;

  typedef struct packed {
    logic selB;
    logic irqEn;
    logic cpMode;
    logic toneEn;
  } ctlA_t;

  typedef struct packed {
    logic highGroup;
    logic oneTone;
    logic testMode;
    logic burstOff;
  } ctlB_t;

  typedef struct packed {
    logic              wrTx;
    logic              wrCtlA;
    logic              wrCtlB;
    logic              rdStat;
    logic [DATA_W-1:0] data;
  } busStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_BURST = 2'd1,
    PH_PAUSE = 2'd2
  } phase_t;
endpackage

// File: rtl/xcvr_bus_ctrl.sv
module xcvr_bus_ctrl
  import tone_xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSelN,
  input  logic              hostAddr,
  input  logic              hostRead,
  input  logic              hostStrobe,
  input  logic [DATA_W-1:0] hostWrData,
  output busStrobe_t        strobes,
  output logic              selPending
);
  logic              prevStrobe;
  logic              prevSelN;
  logic              prevAddr;
  logic              prevRead;
  logic [DATA_W-1:0] prevData;
  logic              accessEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevStrobe <= 1'b0;
      prevSelN   <= 1'b1;
      prevAddr   <= 1'b0;
      prevRead   <= 1'b0;
      prevData   <= '0;
    end else begin
      prevStrobe <= hostStrobe;
      prevSelN   <= hostSelN;
      prevAddr   <= hostAddr;
      prevRead   <= hostRead;
      prevData   <= hostWrData;
    end
  end

  // Access completes on the edge after the strobe falls, using the
  // attributes seen during the last strobe cycle.
  assign accessEnd = prevStrobe && !hostStrobe && !prevSelN;

  always_comb begin
    strobes        = '0;
    strobes.data   = prevData;
    strobes.wrTx   = accessEnd && !prevRead && !prevAddr;
    strobes.wrCtlA = accessEnd && !prevRead && prevAddr && !selPending;
    strobes.wrCtlB = accessEnd && !prevRead && prevAddr && selPending;
    strobes.rdStat = accessEnd && prevRead && prevAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selPending <= 1'b0;
    end else if (strobes.wrCtlA) begin
      selPending <= prevData[3];
    end else if (strobes.wrCtlB) begin
      selPending <= 1'b0;
    end
  end
endmodule

// File: rtl/xcvr_burst_timer.sv
module xcvr_burst_timer
  import tone_xcvr_pkg::*;
#(
  parameter int TICK_DIV    = 250000,
  parameter int BURST_TICKS = 51
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic burstOn,
  input  logic cpMode,
  output logic burstActive,
  output logic burstDone
);
  localparam int LONG_TICKS = 2 * BURST_TICKS;
  localparam int DIV_W      = $clog2(TICK_DIV) + 1;
  localparam int TICK_W     = $clog2(LONG_TICKS) + 1;

  phase_t            phase;
  logic [DIV_W-1:0]  divCnt;
  logic [TICK_W-1:0] tickCnt;
  logic [TICK_W-1:0] lenQ;
  logic              tick;
  logic              lastTick;

  assign tick     = (divCnt == DIV_W'(TICK_DIV - 1));
  assign lastTick = tick && (tickCnt == lenQ - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || !burstOn) begin
      phase   <= PH_IDLE;
      divCnt  <= '0;
      tickCnt <= '0;
      lenQ    <= TICK_W'(BURST_TICKS);
    end else if (start) begin
      phase   <= PH_BURST;
      divCnt  <= '0;
      tickCnt <= '0;
      lenQ    <= cpMode ? TICK_W'(LONG_TICKS) : TICK_W'(BURST_TICKS);
    end else if (phase != PH_IDLE) begin
      if (tick) begin
        divCnt <= '0;
        if (lastTick) begin
          tickCnt <= '0;
          phase   <= (phase == PH_BURST) ? PH_PAUSE : PH_IDLE;
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign burstActive = (phase == PH_BURST);
  assign burstDone   = burstOn && !start && (phase == PH_PAUSE) && lastTick;
endmodule

// File: rtl/xcvr_regfile.sv
module xcvr_regfile
  import tone_xcvr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  busStrobe_t        strobes,
  input  logic              hostSelN,
  input  logic              hostAddr,
  input  logic              hostRead,
  input  logic              hostStrobe,
  input  logic              rxLatched,
  input  logic [DATA_W-1:0] rxCode,
  input  logic              rxSteer,
  input  logic              burstActive,
  input  logic              burstDone,
  output ctlA_t             ctlAQ,
  output ctlB_t             ctlBQ,
  output logic              txEmptyQ,
  output logic              rxFullQ,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostRdOe,
  output logic [DATA_W-1:0] txDigit,
  output logic              toneGate,
  output logic              irqN
);
  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] statusWord;
  logic              txEmptyVis;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlAQ   <= '0;
      ctlBQ   <= '0;
      txDigit <= '0;
      rxReg   <= '0;
    end else begin
      if (strobes.wrCtlA) ctlAQ   <= ctlA_t'(strobes.data);
      if (strobes.wrCtlB) ctlBQ   <= ctlB_t'(strobes.data);
      if (strobes.wrTx)   txDigit <= strobes.data;
      if (rxLatched)      rxReg   <= rxCode;
    end
  end

  // Set wins over the read clear so an event on the clearing edge survives.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFullQ  <= 1'b0;
      txEmptyQ <= 1'b0;
    end else begin
      if (rxLatched)           rxFullQ <= 1'b1;
      else if (strobes.rdStat) rxFullQ <= 1'b0;

      if (ctlBQ.burstOff)      txEmptyQ <= 1'b0;
      else if (burstDone)      txEmptyQ <= 1'b1;
      else if (strobes.rdStat) txEmptyQ <= 1'b0;
    end
  end

  assign txEmptyVis = txEmptyQ && !ctlBQ.burstOff;
  assign statusWord = {!rxSteer, rxFullQ, txEmptyVis, rxFullQ || txEmptyVis};

  always_comb begin
    hostRdOe   = hostStrobe && !hostSelN && hostRead;
    hostRdData = '0;
    if (hostRdOe) hostRdData = hostAddr ? statusWord : rxReg;
  end

  assign toneGate = ctlAQ.toneEn && (ctlBQ.burstOff || burstActive);

  always_comb begin
    if (ctlAQ.cpMode)        irqN = 1'b1;
    else if (ctlBQ.testMode) irqN = !rxSteer;
    else if (ctlAQ.irqEn)    irqN = !(rxFullQ || txEmptyVis);
    else                     irqN = 1'b1;
  end
endmodule

// File: rtl/tone_xcvr_hostif.sv
module tone_xcvr_hostif
  import tone_xcvr_pkg::*;
#(
  parameter int TICK_DIV    = 250000,
  parameter int BURST_TICKS = 51
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSelN,
  input  logic        hostAddr,
  input  logic        hostRead,
  input  logic        hostStrobe,
  input  logic [3:0]  hostWrData,
  output logic [3:0]  hostRdData,
  output logic        hostRdOe,
  input  logic        rxLatched,
  input  logic [3:0]  rxCode,
  input  logic        rxSteer,
  output logic [3:0]  txDigit,
  output logic        toneGate,
  output logic        oneTone,
  output logic        highGroup,
  output logic        irqN
);
  busStrobe_t strobes;
  logic       selPending;
  ctlA_t      ctlAQ;
  ctlB_t      ctlBQ;
  logic       txEmptyQ;
  logic       rxFullQ;
  logic       burstActive;
  logic       burstDone;

  xcvr_bus_ctrl u_ctrl (
    .clk, .rstN, .hostSelN, .hostAddr, .hostRead, .hostStrobe, .hostWrData,
    .strobes, .selPending
  );

  xcvr_burst_timer #(.TICK_DIV(TICK_DIV), .BURST_TICKS(BURST_TICKS)) u_timer (
    .clk, .rstN,
    .start(strobes.wrTx && !ctlBQ.burstOff),
    .burstOn(!ctlBQ.burstOff),
    .cpMode(ctlAQ.cpMode),
    .burstActive, .burstDone
  );

  xcvr_regfile u_regs (
    .clk, .rstN, .strobes, .hostSelN, .hostAddr, .hostRead, .hostStrobe,
    .rxLatched, .rxCode, .rxSteer, .burstActive, .burstDone,
    .ctlAQ, .ctlBQ, .txEmptyQ, .rxFullQ, .hostRdData, .hostRdOe,
    .txDigit, .toneGate, .irqN
  );

  assign oneTone   = ctlBQ.oneTone;
  assign highGroup = ctlBQ.highGroup;
endmodule

// File: rtl/tone_xcvr_checker.sv
module tone_xcvr_checker
  import tone_xcvr_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       hostSelN,
  input logic       hostRead,
  input logic       hostStrobe,
  input logic       hostRdOe,
  input logic       toneGate,
  input logic       irqN,
  input logic       rxLatched,
  input ctlA_t      ctlAQ,
  input ctlB_t      ctlBQ,
  input logic       txEmptyQ,
  input logic       rxFullQ,
  input busStrobe_t strobes,
  input logic       selPending
);
  // R3: the B select is one-shot
  p_ctlb_oneshot_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrCtlB |=> !selPending);

  // R4: the tone gate never opens without the tone enable bit
  p_gate_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    toneGate |-> ctlAQ.toneEn);

  // R6: burst off keeps the transmit-empty flag clear
  p_nonburst_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctlBQ.burstOff |=> !txEmptyQ);

  // R7: a status read with no coinciding receive event clears receive full
  p_status_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStat && !rxLatched) |=> !rxFullQ);

  // R7: a receive event always leaves the flag set
  p_rx_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxLatched |=> rxFullQ);

  // R8: call-progress mode silences the interrupt output
  p_irq_quiet_cp_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctlAQ.cpMode |-> irqN);

  // R11: read data is driven only during a selected read strobe
  p_oe_only_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    hostRdOe |-> (!hostSelN && hostRead && hostStrobe));
endmodule

bind tone_xcvr_hostif tone_xcvr_checker u_chk (
  .clk, .rstN, .hostSelN, .hostRead, .hostStrobe, .hostRdOe, .toneGate, .irqN,
  .rxLatched, .ctlAQ, .ctlBQ, .txEmptyQ, .rxFullQ, .strobes, .selPending
);

// File: tb/tb_tone_xcvr_hostif.sv
module tb_tone_xcvr_hostif;
  localparam int TDIV = 4;
  localparam int BT   = 51;
  localparam int L    = TDIV * BT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostSelN = 1'b1, hostAddr = 1'b0, hostRead = 1'b0, hostStrobe = 1'b0;
  logic [3:0] hostWrData = '0;
  logic [3:0] hostRdData;
  logic       hostRdOe;
  logic       rxLatched = 1'b0;
  logic [3:0] rxCode = '0;
  logic       rxSteer = 1'b0;
  logic [3:0] txDigit;
  logic       toneGate, oneTone, highGroup, irqN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [3:0] mA = '0, mB = '0, mRx = '0;
  bit mSel = 0, mRxFull = 0, mTxE = 0;

  always #2 clk = ~clk;

  tone_xcvr_hostif #(.TICK_DIV(TDIV), .BURST_TICKS(BT)) dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expStatus();
    logic txv = mTxE && !mB[0];
    return {!rxSteer, mRxFull, txv, mRxFull || txv};
  endfunction

  function automatic logic expIrqN();
    logic txv = mTxE && !mB[0];
    if (mA[1]) return 1'b1;
    if (mB[1]) return !rxSteer;
    if (mA[2]) return !(mRxFull || txv);
    return 1'b1;
  endfunction

  function automatic logic expGate();
    return mA[0] && mB[0];
  endfunction

  task automatic busOp(input bit rd, input bit addr, input logic [3:0] wd,
                       input bit selN, output logic [3:0] rdv, output logic oe);
    @(negedge clk);
    hostSelN = selN; hostRead = rd; hostAddr = addr; hostWrData = wd; hostStrobe = 1'b1;
    @(negedge clk);
    rdv = hostRdData; oe = hostRdOe;
    hostStrobe = 1'b0; hostSelN = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctlWrite(input logic [3:0] d);
    logic [3:0] v; logic oe;
    busOp(1'b0, 1'b1, d, 1'b0, v, oe);
    if (mSel) begin mB = d; mSel = 0; end
    else begin mA = d; mSel = d[3]; end
  endtask

  task automatic statusRead(string tag, bit doCheck);
    logic [3:0] v; logic oe;
    logic [3:0] e = expStatus();
    busOp(1'b1, 1'b1, 4'h0, 1'b0, v, oe);
    if (doCheck) chk(tag, v, e);
    mRxFull = 0; mTxE = 0;
  endtask

  task automatic rxEvent(input logic [3:0] code);
    @(negedge clk);
    rxLatched = 1'b1; rxCode = code;
    @(negedge clk);
    rxLatched = 1'b0;
    mRxFull = 1; mRx = code;
  endtask

  task automatic measureBurst(string tag, int len);
    int gateFall = 0, irqFall = 0;
    logic [3:0] v; logic oe;
    busOp(1'b0, 1'b0, 4'h7, 1'b0, v, oe);
    for (int i = 1; i <= 2 * len + 8; i++) begin
      if (gateFall == 0 && toneGate == 1'b0) gateFall = i;
      if (irqFall == 0 && irqN == 1'b0) irqFall = i;
      @(negedge clk);
    end
    chk({tag, " gate fall index"}, gateFall, len + 1);
    if (!mA[1]) chk({tag, " ready irq index"}, irqFall, 2 * len + 1);
    else        chk({tag, " irq stays high in cp"}, irqFall, 0);
    mTxE = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] v; logic oe;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10 toneGate", toneGate, 1'b0);
    chk("R10 irqN", irqN, 1'b1);
    chk("R10 oneTone", oneTone, 1'b0);
    statusRead("R10 status", 1);

    // random mix: R2 R3 R7 R8 R9
    for (int n = 0; n < 80; n++) begin
      int op = $urandom_range(0, 3);
      case (op)
        0: ctlWrite(4'($urandom_range(0, 15)));
        1: begin rxSteer = 1'($urandom_range(0, 1)); rxEvent(4'($urandom_range(0, 15))); end
        2: statusRead("R7 random status", 1);
        default: begin
          busOp(1'b1, 1'b0, 4'h0, 1'b0, v, oe);
          chk("R2 random rx read", v, mRx);
        end
      endcase
      chk("R3 random oneTone", oneTone, mB[2]);
      chk("R3 random highGroup", highGroup, mB[3]);
      chk("R6 random toneGate", toneGate, expGate());
      chk("R8 random irqN", irqN, expIrqN());
    end

    // normalise control state
    rxSteer = 1'b0;
    ctlWrite(4'h0); ctlWrite(4'h0);
    ctlWrite(4'hD); ctlWrite(4'h0);
    statusRead("clear", 0);

    // R4 + R1: normal burst
    measureBurst("R4", L);
    chk("R1 txDigit", txDigit, 4'h7);
    statusRead("R7 after burst", 1);
    chk("R8 irq released after read", irqN, 1'b1);
    statusRead("R7 flags cleared", 1);

    // R5: call-progress doubles both phases
    ctlWrite(4'h7);
    measureBurst("R5", 2 * L);
    repeat (2 * L + 4) @(negedge clk);
    statusRead("R5 ready after long pause", 1);

    // R6: burst off
    ctlWrite(4'h9); ctlWrite(4'h1);
    repeat (3 * L) @(negedge clk);
    chk("R6 gate follows enable", toneGate, 1'b1);
    statusRead("R6 no tx empty", 1);
    ctlWrite(4'h0);
    chk("R6 gate off", toneGate, 1'b0);

    // R3: one-shot B select
    ctlWrite(4'h8); ctlWrite(4'h7); ctlWrite(4'h1);
    chk("R3 B took write", oneTone, 1'b1);
    chk("R3 A took next write", toneGate, 1'b1);

    // R9: test mode
    rxSteer = 1'b1; @(negedge clk);
    chk("R9 test irqN steer high", irqN, 1'b0);
    rxSteer = 1'b0; @(negedge clk);
    chk("R9 test irqN steer low", irqN, 1'b1);
    ctlWrite(4'h3);
    rxSteer = 1'b1; @(negedge clk);
    chk("R9 test ignored in cp", irqN, 1'b1);
    rxSteer = 1'b0;

    // R11: unselected accesses
    busOp(1'b0, 1'b1, 4'h0, 1'b1, v, oe);
    chk("R11 unselected write ignored", toneGate, 1'b1);
    busOp(1'b1, 1'b1, 4'h0, 1'b1, v, oe);
    chk("R11 no drive when unselected", oe, 1'b0);
    busOp(1'b1, 1'b0, 4'h0, 1'b0, v, oe);
    chk("R11 drive on selected read", oe, 1'b1);

    // R7: receive event on the edge that ends a status read
    ctlWrite(4'hC); ctlWrite(4'h1);
    statusRead("clear", 0);
    @(negedge clk);
    hostSelN = 1'b0; hostRead = 1'b1; hostAddr = 1'b1; hostStrobe = 1'b1;
    @(negedge clk);
    hostStrobe = 1'b0; hostSelN = 1'b1; rxLatched = 1'b1; rxCode = 4'h9;
    @(negedge clk);
    rxLatched = 1'b0;
    mRxFull = 1; mRx = 4'h9;
    chk("R8 irq on coinciding rx", irqN, 1'b0);
    statusRead("R7 set survives clear", 1);
    busOp(1'b1, 1'b0, 4'h0, 1'b0, v, oe);
    chk("R2 rx code", v, 4'h9);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule